// File: doc/BRIEF.md
# Double-Width Funnel Shift Unit

This block executes a pair of funnel shift operations on a 64-bit data path. It places two doublewords side by side to form a 128-bit value, shifts that value left or right by an amount taken from a third operand, and returns one 64-bit half. A left shift returns the upper half and a right shift returns the lower half. The shift amount is always reduced modulo 64.

Three register values enter the unit: the old contents of the destination register and two ordinary sources. A 2-bit selector decides which of them supplies the upper half, the lower half and the shift amount, so the destination register can also serve as a source. One selector value swaps in an all-zero half instead. The zero is the upper half for a left shift and the lower half for a right shift. When the record bit is set, the unit also produces a 4-bit condition field from the result. The unit has a single register stage with one cycle of latency.

Top module: `funnel_shift_unit`

## Requirements
- R1: With selector 0, the upper half is the old destination value, the lower half is source A, and the amount is source B.
- R2: With selector 1, the upper half is source A, the lower half is the old destination value, and the amount is source B.
- R3: With selector 2, the upper half is source A, the lower half is source B, and the amount is the old destination value.
- R4: With selector 3, the amount is source B. On a left shift the upper half is zero and the lower half is source A. On a right shift the upper half is source A and the lower half is zero.
- R5: Only the 6 least significant bits of the amount operand count. Bits above them have no effect on the result.
- R6: A left shift (dir_left_i=1) returns bits 127:64 of {upper, lower} shifted left by n.
- R7: A right shift (dir_left_i=0) returns bits 63:0 of {upper, lower} shifted right logically by n.
- R8: With n = 0, a left shift returns the upper half unchanged and a right shift returns the lower half unchanged.
- R9: When rec_i=1, cond_we_o is 1 and cond_o is {neg, pos, zero, sum_ovf_i}. Bit 3 is set when the result is negative as a signed number. Bit 2 is set when it is greater than zero. Bit 1 is set when it equals zero. Bit 0 copies sum_ovf_i.
- R10: When rec_i=0, cond_we_o is 0 and cond_o is 0.
- R11: A request accepted while in_valid is high appears on the outputs with out_valid high exactly one clock later. A synchronous reset clears out_valid, result_o, cond_o and cond_we_o.
- R12: In a cycle with in_valid low, out_valid falls and result_o, cond_o and cond_we_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| dst_old_i | input | 64 | Old value of the destination register |
| src_a_i | input | 64 | Source operand A |
| src_b_i | input | 64 | Source operand B |
| dir_left_i | input | 1 | 1 = left shift, 0 = right shift |
| sel_mode_i | input | 2 | Operand role selector, values 0 to 3 |
| rec_i | input | 1 | Record bit: produce a condition field |
| sum_ovf_i | input | 1 | Summary overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| result_o | output | 64 | Shifted 64-bit half |
| cond_o | output | 4 | Condition field {neg, pos, zero, ovf} |
| cond_we_o | output | 1 | Condition field update signalled |

## Verification
The bench builds the unit with the default width of 64, so the amount field is 6 bits wide. At this width it can reach amounts of 0, 1, 31, 32 and 63. It can also apply amounts that set bits above the field, to show that those bits are masked. Every selector value is driven in both directions, and the old destination value is different from both sources, so a swapped operand role changes the expected value. The operands are chosen so that results come out negative, positive and exactly zero, and both settings of the record bit are used.

// File: rtl/funnel_shift_pkg.sv
package funnel_shift_pkg;

    typedef enum logic [1:0] {
        ROLE_OLD_UPPER = 2'd0,
        ROLE_OLD_LOWER = 2'd1,
        ROLE_OLD_AMT   = 2'd2,
        ROLE_ZERO_FILL = 2'd3
    } role_sel_e;

    localparam int COND_W     = 4;
    localparam int COND_NEG   = 3;
    localparam int COND_POS   = 2;
    localparam int COND_ZERO  = 1;
    localparam int COND_OVF   = 0;

endpackage

// File: rtl/funnel_operand_route.sv
module funnel_operand_route
    import funnel_shift_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] dst_old,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            dir_left,
    input  role_sel_e       role,
    output logic [XLEN-1:0] upper,
    output logic [XLEN-1:0] lower,
    output logic [XLEN-1:0] amount
);
    always_comb begin
        upper  = dst_old;
        lower  = src_a;
        amount = src_b;
        unique case (role)
            ROLE_OLD_UPPER: begin
                upper  = dst_old;
                lower  = src_a;
                amount = src_b;
            end
            ROLE_OLD_LOWER: begin
                upper  = src_a;
                lower  = dst_old;
                amount = src_b;
            end
            ROLE_OLD_AMT: begin
                upper  = src_a;
                lower  = src_b;
                amount = dst_old;
            end
            ROLE_ZERO_FILL: begin
                upper  = dir_left ? '0 : src_a;
                lower  = dir_left ? src_a : '0;
                amount = src_b;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/funnel_core.sv
module funnel_core #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] upper,
    input  logic [XLEN-1:0] lower,
    input  logic [SHW-1:0]  amt,
    input  logic            dir_left,
    output logic [XLEN-1:0] result
);
    logic [2*XLEN-1:0] joined;
    logic [2*XLEN-1:0] shl;
    logic [2*XLEN-1:0] shr;

    always_comb begin
        joined = {upper, lower};
        shl    = joined << amt;
        shr    = joined >> amt;
        result = dir_left ? shl[2*XLEN-1:XLEN] : shr[XLEN-1:0];
    end
endmodule

// File: rtl/funnel_cond_gen.sv
module funnel_cond_gen
    import funnel_shift_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   value,
    input  logic              ovf_in,
    input  logic              enable,
    output logic [COND_W-1:0] cond
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = value[XLEN-1];
        is_zero = (value == '0);
        cond    = '0;
        if (enable) begin
            cond[COND_NEG]  = is_neg;
            cond[COND_POS]  = !is_neg && !is_zero;
            cond[COND_ZERO] = is_zero;
            cond[COND_OVF]  = ovf_in;
        end
    end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
    import funnel_shift_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] dst_old_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic            dir_left_i,
    input  logic [1:0]      sel_mode_i,
    input  logic            rec_i,
    input  logic            sum_ovf_i,
    output logic            out_valid,
    output logic [XLEN-1:0] result_o,
    output logic [3:0]      cond_o,
    output logic            cond_we_o
);
    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   res;
        logic [COND_W-1:0] cond;
        logic              we;
    } stage_t;

    stage_t state_d, state_q;

    logic [XLEN-1:0]   upper_w, lower_w, amount_w, shifted_w;
    logic [COND_W-1:0] cond_w;
    role_sel_e         role_w;

    assign role_w = role_sel_e'(sel_mode_i);

    funnel_operand_route #(.XLEN(XLEN)) u_route (
        .dst_old  (dst_old_i),
        .src_a    (src_a_i),
        .src_b    (src_b_i),
        .dir_left (dir_left_i),
        .role     (role_w),
        .upper    (upper_w),
        .lower    (lower_w),
        .amount   (amount_w)
    );

    funnel_core #(.XLEN(XLEN)) u_core (
        .upper    (upper_w),
        .lower    (lower_w),
        .amt      (amount_w[SHW-1:0]),
        .dir_left (dir_left_i),
        .result   (shifted_w)
    );

    funnel_cond_gen #(.XLEN(XLEN)) u_cond (
        .value  (shifted_w),
        .ovf_in (sum_ovf_i),
        .enable (rec_i),
        .cond   (cond_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.res  = shifted_w;
            state_d.cond = cond_w;
            state_d.we   = rec_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result_o  = state_q.res;
    assign cond_o    = state_q.cond;
    assign cond_we_o = state_q.we;
endmodule

// File: rtl/funnel_shift_unit_checker.sv
module funnel_shift_unit_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [XLEN-1:0] dst_old_i,
    input logic [XLEN-1:0] src_a_i,
    input logic [XLEN-1:0] src_b_i,
    input logic            dir_left_i,
    input logic [1:0]      sel_mode_i,
    input logic            rec_i,
    input logic            sum_ovf_i,
    input logic            out_valid,
    input logic [XLEN-1:0] result_o,
    input logic [3:0]      cond_o,
    input logic            cond_we_o
);
    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && !cond_we_o && result_o == '0));

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result_o) && $stable(cond_o) && $stable(cond_we_o)));

    p_cond_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cond_we_o) |-> ($onehot(cond_o[3:1]) && (cond_o[1] == (result_o == '0))
                                      && (cond_o[3] == result_o[XLEN-1])));

    p_ovf_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rec_i) |=> (cond_we_o && cond_o[0] == $past(sum_ovf_i)));

    p_no_record_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rec_i) |=> (!cond_we_o && cond_o == 4'd0));

    p_zero_amt_left_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir_left_i && sel_mode_i == 2'd0 && src_b_i[5:0] == 6'd0)
        |=> (result_o == $past(dst_old_i)));

    p_zero_amt_right_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_left_i && sel_mode_i == 2'd0 && src_b_i[5:0] == 6'd0)
        |=> (result_o == $past(src_a_i)));
endmodule

bind funnel_shift_unit funnel_shift_unit_checker #(.XLEN(XLEN)) u_checker (.*);

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] dst_old_i = '0, src_a_i = '0, src_b_i = '0;
    logic        dir_left_i = 1'b0;
    logic [1:0]  sel_mode_i = '0;
    logic        rec_i = 1'b0, sum_ovf_i = 1'b0;
    logic        out_valid;
    logic [63:0] result_o;
    logic [3:0]  cond_o;
    logic        cond_we_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    funnel_shift_unit u_funnel_shift_unit (.*);

    typedef struct {
        logic [63:0] res;
        logic [3:0]  cond;
        logic        we;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    logic [63:0] last_res = '0;
    logic [3:0]  last_cond = '0;
    logic        last_we = 1'b0;
    bit          finished = 0;

    function automatic logic [63:0] model(input logic [1:0] m, input logic left,
                                          input logic [63:0] t, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0]  hi, lo, sh;
        logic [127:0] v;
        case (m)
            2'd0: begin hi = t; lo = a; sh = b; end
            2'd1: begin hi = a; lo = t; sh = b; end
            2'd2: begin hi = a; lo = b; sh = t; end
            default: begin hi = left ? 64'd0 : a; lo = left ? a : 64'd0; sh = b; end
        endcase
        v = {hi, lo};
        if (left) return 64'(((v << sh[5:0]) >> 64));
        return 64'(v >> sh[5:0]);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic left, input logic [63:0] t,
                         input logic [63:0] a, input logic [63:0] b, input logic rec, input logic ovf);
        exp_t e;
        logic [63:0] amt;
        e.res  = model(m, left, t, a, b);
        e.we   = rec;
        e.cond = rec ? {e.res[63], !e.res[63] && e.res != 0, e.res == 0, ovf} : 4'd0;
        amt    = (m == 2'd2) ? t : b;
        e.tag  = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R4";
        e.tag  = {e.tag, left ? "/R6" : "/R7"};
        if (amt[63:6] != 0) e.tag = {e.tag, "/R5"};
        if (amt[5:0] == 0)  e.tag = {e.tag, "/R8"};
        e.tag  = {e.tag, rec ? "/R9" : "/R10"};
        q.push_back(e);
        dst_old_i = t; src_a_i = a; src_b_i = b;
        sel_mode_i = m; dir_left_i = left; rec_i = rec; sum_ovf_i = ovf;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: scoreboard pops one expected item per valid result (R11)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11 unexpected out_valid", result_o, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(result_o == e.res, e.tag, result_o, e.res);
                    check(cond_o == e.cond && cond_we_o == e.we, {e.tag, " cond"},
                          {59'd0, cond_we_o, cond_o}, {59'd0, e.we, e.cond});
                    last_res = e.res; last_cond = e.cond; last_we = e.we;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] hi_v, lo_v, t_v;
        hi_v = 64'h0123456789ABCDEF;
        lo_v = 64'hFEDCBA9876543210;
        t_v  = 64'h8000_0000_F00D_0001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check(out_valid == 1'b0 && cond_we_o == 1'b0, "R11 reset valid", {63'd0, out_valid}, 64'd0);
        check(result_o == 64'd0, "R11 reset result", result_o, 64'd0);

        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                logic [63:0] amts [8];
                amts = '{64'd0, 64'd1, 64'd4, 64'd31, 64'd32, 64'd63, 64'h45, 64'hFFFF_0000_0000_0024};
                for (int k = 0; k < 8; k++) begin
                    if (m == 2)
                        drive(2'(m), d[0], amts[k], hi_v, lo_v, k[0], k[1]);
                    else
                        drive(2'(m), d[0], t_v, lo_v, amts[k], k[0], k[1]);
                end
            end
        end
        // R9: zero result with record set (selector 3 right, source A zero)
        drive(2'd3, 1'b0, t_v, 64'd0, 64'd7, 1'b1, 1'b1);
        // R9: positive result, R4 left with zero upper
        drive(2'd3, 1'b1, t_v, 64'hF000_0000_0000_0000, 64'd3, 1'b1, 1'b0);
        // R5: amount 64 behaves as 0 -> returns upper unchanged
        drive(2'd0, 1'b1, t_v, lo_v, 64'd64, 1'b1, 1'b0);
        // back-to-back then idle
        drive(2'd1, 1'b0, t_v, hi_v, 64'd8, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        // R12: outputs hold during idle cycles
        check(out_valid == 1'b0, "R12 out_valid low when idle", {63'd0, out_valid}, 64'd0);
        check(result_o == last_res, "R12 result held", result_o, last_res);
        check(cond_o == last_cond && cond_we_o == last_we, "R12 cond held",
              {59'd0, cond_we_o, cond_o}, {59'd0, last_we, last_cond});
        check(q.size() == 0, "R11 all results delivered", 64'(q.size()), 64'd0);
        // R11: synchronous reset clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0 && result_o == 64'd0 && cond_o == 4'd0 && cond_we_o == 1'b0,
              "R11 reset clears outputs", result_o, 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule